// File: doc/BRIEF.md
# I2C Target Select Receiver with Bus Watchdog

This block sits on the target side of a two-wire serial bus. It watches the clock and data lines, sampling them on the system clock, and finds the Start and Stop conditions. After a Start it shifts in the first byte of the transaction, the device select byte, and compares it with a fixed four-bit type code and three chip-enable strap pins. When both agree, it pulls the data line low for the ninth clock to acknowledge, raises a selected flag and reports the direction bit. When they do not agree, it stays off the bus and ignores everything until the next Start.

A watchdog guards the transfer. If the first rising clock edge after a Start comes too late, or if any high or low clock phase lasts too long, the receiver drops the transaction. It emits a one-cycle timeout pulse and ignores traffic until a fresh Start. All three limits are run-time inputs counted in system clock cycles, each at least 1. The address bytes and the memory behind the block are handled elsewhere.

Top module: `i2c_tgt_front`

## Requirements
- R1: While reset is low and in the first cycle after it, `sda_pull_o`, `sel_o`, `rw_o` and `timeout_o` are all 0.
- R2: A Start is a falling data line while the clock line is high, and it begins reception of a device select byte. A Stop is a rising data line while the clock is high, and it clears `sel_o` and `rw_o` and returns the block to idle.
- R3: Device select bits are sampled on rising clock edges, most significant bit first. The byte is accepted only when bits 7..4 equal 4'b1010 and bits 3..1 equal `ce_strap[2:0]`. Bit 0 is the direction bit, where 1 means read and 0 means write.
- R4: On an accepted byte, `sda_pull_o` rises after the falling clock edge that ends bit 8 and falls after the falling clock edge that ends bit 9. It is 0 at all other times.
- R5: `sel_o` rises together with the acknowledge and stays high until a Stop, a Start or a timeout. While selected, `rw_o` holds bit 0 of the accepted byte. Otherwise it is 0.
- R6: On a rejected byte there is no acknowledge. Later bytes are ignored until the next Start, even one that would match.
- R7: If the first rising clock edge comes more than `start_lim` cycles after the Start's data fall, the transaction is aborted. Only this limit applies before that first rising edge.
- R8: After the first rising edge, a clock high phase longer than `high_lim` cycles aborts the transaction.
- R9: After the first rising edge, including while selected, a clock low phase longer than `low_lim` cycles aborts the transaction.
- R10: Each abort produces exactly one single-cycle `timeout_o` pulse, clears `sel_o` and `sda_pull_o`, and makes the block ignore traffic until the next Start.
- R11: A Stop in mid-byte discards the partial byte, and the bits that follow are ignored. A repeated Start in mid-byte discards the partial byte and restarts reception, so a matching byte sent after it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level (asynchronous) |
| sda_i | input | 1 | Serial data line level (asynchronous) |
| ce_strap | input | 3 | Chip-enable strap pins compared with select bits 3..1 |
| start_lim | input | CNT_W | Maximum cycles from Start to first rising clock edge |
| high_lim | input | CNT_W | Maximum cycles of a clock high phase |
| low_lim | input | CNT_W | Maximum cycles of a clock low phase |
| sda_pull_o | output | 1 | Data line pull-down enable (acknowledge) |
| sel_o | output | 1 | Device selected |
| rw_o | output | 1 | Direction bit of the accepted byte |
| timeout_o | output | 1 | One-cycle pulse on a watchdog abort |

## Verification
The bench sends all 256 select bytes against one strap setting and every chip-enable value against every strap setting. A wrong nibble compare or bit order would acknowledge foreign bytes or miss its own. Each watchdog limit is swept one cycle below, at and above its boundary. An off-by-one counter would then abort a legal phase or let an illegal one through. The Start window is tested with a long low phase before the first rise, which catches a design that applies the low-phase limit too early. Standby after a mismatch, a Stop or repeated Start in mid-byte, and a low timeout while selected are driven separately, since a design that forgets to clear its shift state would still acknowledge in those cases.

// File: rtl/i2c_tgt_pkg.sv
// Package: shared constants and the receiver state type for the I2C
// target select receiver. Assumes an 8-bit select byte made of a type
// code, a chip-enable field and a direction bit.
package i2c_tgt_pkg;

    localparam int TYPE_W    = 4;
    localparam int CE_W      = 3;
    localparam int BYTE_BITS = TYPE_W + CE_W + 1;
    localparam int BIT_CNT_W = $clog2(BYTE_BITS + 1);

    localparam logic [TYPE_W-1:0] DEV_TYPE_ID = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,   // standby: ignore everything but Start
        ST_ARMED = 3'd1,   // Start seen, waiting for first rising clock
        ST_SHIFT = 3'd2,   // collecting select bits
        ST_ACK   = 3'd3,   // driving the acknowledge bit
        ST_SEL   = 3'd4    // selected, watching the bus
    } rx_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Line synchroniser and bus-condition decoder.
// Brings the asynchronous clock and data lines into the system clock
// domain through SYNC_STAGES flops. It then flags clock edges and
// Start/Stop conditions, each as a one-cycle strobe. Assumes the lines
// idle high and the master never moves both lines in the same cycle.
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_sh;
    logic [SYNC_STAGES-1:0] sda_sh;
    logic                   scl_prev;
    logic                   sda_prev;

    // Synchroniser chains plus one history flop per line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh   <= '1;
            sda_sh   <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sh   <= {scl_sh[SYNC_STAGES-2:0], scl_i};
            sda_sh   <= {sda_sh[SYNC_STAGES-2:0], sda_i};
            scl_prev <= scl_sh[SYNC_STAGES-1];
            sda_prev <= sda_sh[SYNC_STAGES-1];
        end
    end

    // Edge and bus-condition strobes from current versus previous level.
    always_comb begin
        scl_lvl   = scl_sh[SYNC_STAGES-1];
        sda_lvl   = sda_sh[SYNC_STAGES-1];
        scl_rise  = scl_lvl & ~scl_prev;
        scl_fall  = ~scl_lvl & scl_prev;
        start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
        stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
    end

endmodule

// File: rtl/i2c_phase_watchdog.sv
// Clock-phase watchdog.
// Counts system cycles since the last timing event. While armed, the
// only events are the restart and the first rising clock edge, and the
// limit is start_lim. Otherwise any clock edge is an event, and the
// limit follows the current clock level. abort is asserted when a
// window longer than its limit would otherwise elapse. Assumes limits
// are at least 1.
module i2c_phase_watchdog #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             armed,
    input  logic             restart,
    input  logic             scl_lvl,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic [CNT_W-1:0] start_lim,
    input  logic [CNT_W-1:0] high_lim,
    input  logic [CNT_W-1:0] low_lim,
    output logic             abort
);

    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;
    logic             phase_evt;

    // Pick the event set and the limit that apply in the current phase.
    always_comb begin
        phase_evt = armed ? scl_rise : (scl_rise | scl_fall);
        if (armed) begin
            lim = start_lim;
        end else if (scl_lvl) begin
            lim = high_lim;
        end else begin
            lim = low_lim;
        end
        abort = active & ~restart & ~phase_evt & (cnt_q >= lim);
    end

    // Phase length counter, saturating, restarted at every event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_ONE;
        end else if (restart || (active && phase_evt)) begin
            cnt_q <= CNT_ONE;
        end else if (active && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

endmodule

// File: rtl/i2c_select_rx.sv
// Device select receiver and acknowledge sequencer.
// Shifts in the select byte on rising clock edges and decides on the
// falling edge that ends bit 8. On a match it drives the acknowledge
// for bit 9 and then holds the selected state. Start re-arms; Stop and
// watchdog abort return to idle. Assumes strobes from i2c_line_sync.
module i2c_select_rx
    import i2c_tgt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sda_lvl,
    input  logic            scl_rise,
    input  logic            scl_fall,
    input  logic            start_det,
    input  logic            stop_det,
    input  logic            abort,
    input  logic [CE_W-1:0] strap,
    output rx_state_t       state,
    output logic            sda_pull,
    output logic            sel,
    output logic            rw,
    output logic            timeout
);

    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_BITS);

    rx_state_t              state_q;
    logic [BYTE_BITS-1:0]   shreg_q;
    logic [BIT_CNT_W-1:0]   bit_cnt_q;
    logic                   match;

    // Compare the collected byte with the type code and strap pins.
    always_comb begin
        match = (shreg_q[BYTE_BITS-1 -: TYPE_W] == DEV_TYPE_ID) &&
                (shreg_q[CE_W:1] == strap);
        state = state_q;
    end

    // Receiver sequencing with priority Start, Stop, abort, then bus edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            shreg_q   <= '0;
            bit_cnt_q <= '0;
            sda_pull  <= 1'b0;
            sel       <= 1'b0;
            rw        <= 1'b0;
            timeout   <= 1'b0;
        end else begin
            timeout <= 1'b0;
            if (start_det) begin
                state_q   <= ST_ARMED;
                shreg_q   <= '0;
                bit_cnt_q <= '0;
                sda_pull  <= 1'b0;
                sel       <= 1'b0;
                rw        <= 1'b0;
            end else if (stop_det || abort) begin
                state_q   <= ST_IDLE;
                shreg_q   <= '0;
                bit_cnt_q <= '0;
                sda_pull  <= 1'b0;
                sel       <= 1'b0;
                rw        <= 1'b0;
                timeout   <= abort & ~stop_det;
            end else begin
                unique case (state_q)
                    ST_ARMED: begin
                        if (scl_rise) begin
                            shreg_q   <= {shreg_q[BYTE_BITS-2:0], sda_lvl};
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                            state_q   <= ST_SHIFT;
                        end
                    end
                    ST_SHIFT: begin
                        if (scl_rise && bit_cnt_q != LAST_BIT) begin
                            shreg_q   <= {shreg_q[BYTE_BITS-2:0], sda_lvl};
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end else if (scl_fall && bit_cnt_q == LAST_BIT) begin
                            if (match) begin
                                sda_pull <= 1'b1;
                                sel      <= 1'b1;
                                rw       <= shreg_q[0];
                                state_q  <= ST_ACK;
                            end else begin
                                state_q  <= ST_IDLE;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            sda_pull <= 1'b0;
                            state_q  <= ST_SEL;
                        end
                    end
                    ST_SEL:  ;
                    ST_IDLE: ;
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_tgt_front.sv
// Top level of the I2C target select receiver with bus watchdog.
// Wires the line synchroniser, the phase watchdog and the select
// receiver together. Assumes scl_i/sda_i are the raw line levels and
// that the limits are held stable during a transfer.
module i2c_tgt_front
    import i2c_tgt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [CE_W-1:0]  ce_strap,
    input  logic [CNT_W-1:0] start_lim,
    input  logic [CNT_W-1:0] high_lim,
    input  logic [CNT_W-1:0] low_lim,
    output logic             sda_pull_o,
    output logic             sel_o,
    output logic             rw_o,
    output logic             timeout_o
);

    logic      scl_lvl;
    logic      sda_lvl;
    logic      scl_rise;
    logic      scl_fall;
    logic      start_det;
    logic      stop_det;
    logic      abort;
    logic      active;
    logic      armed;
    rx_state_t state;

    i2c_line_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    // Watchdog runs whenever a transaction is in progress.
    always_comb begin
        active = (state != ST_IDLE);
        armed  = (state == ST_ARMED);
    end

    i2c_phase_watchdog #(
        .CNT_W (CNT_W)
    ) u_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .armed     (armed),
        .restart   (start_det),
        .scl_lvl   (scl_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_lim (start_lim),
        .high_lim  (high_lim),
        .low_lim   (low_lim),
        .abort     (abort)
    );

    i2c_select_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .abort     (abort),
        .strap     (ce_strap),
        .state     (state),
        .sda_pull  (sda_pull_o),
        .sel       (sel_o),
        .rw        (rw_o),
        .timeout   (timeout_o)
    );

endmodule

// File: rtl/i2c_tgt_front_chk.sv
// Property checker for i2c_tgt_front, bound into every instance.
// Relates the output flags to each other and to the decoded bus
// conditions. Assumes the top-level signal names used in the bind.
module i2c_tgt_front_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_lvl,
    input logic start_det,
    input logic stop_det,
    input logic sda_pull_o,
    input logic sel_o,
    input logic rw_o,
    input logic timeout_o
);

    assert_pull_needs_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull_o |-> sel_o)
        else $error("acknowledge driven while not selected");

    assert_pull_rises_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_lvl)
        else $error("acknowledge started with clock high");

    assert_rw_needs_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rw_o |-> sel_o)
        else $error("direction flag set while not selected");

    assert_timeout_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> !timeout_o)
        else $error("timeout pulse longer than one cycle");

    assert_timeout_drops_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (!sel_o && !sda_pull_o))
        else $error("still selected after abort");

    assert_stop_idles_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sel_o && !sda_pull_o))
        else $error("still selected after stop");

    assert_start_rearms_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (!sel_o && !sda_pull_o))
        else $error("still selected after start");

endmodule

bind i2c_tgt_front i2c_tgt_front_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_lvl    (scl_lvl),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .sda_pull_o (sda_pull_o),
    .sel_o      (sel_o),
    .rw_o       (rw_o),
    .timeout_o  (timeout_o)
);

// File: tb/sim_i2c_tgt_front.sv
module sim_i2c_tgt_front;

    localparam int CNT_W = 16;
    localparam int H     = 8;
    localparam int LS    = 20;
    localparam int LH    = 12;
    localparam int LL    = 15;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             scl = 1'b1;
    logic             msda = 1'b1;
    logic             sda_line;
    logic [2:0]       strap = 3'd5;
    logic [CNT_W-1:0] start_lim = CNT_W'(LS);
    logic [CNT_W-1:0] high_lim = CNT_W'(LH);
    logic [CNT_W-1:0] low_lim = CNT_W'(LL);
    logic             sda_pull_o;
    logic             sel_o;
    logic             rw_o;
    logic             timeout_o;

    int tests = 0;
    int fails = 0;
    int tmo_total = 0;

    always #5 clk = ~clk;

    assign sda_line = msda & ~sda_pull_o;

    i2c_tgt_front #(.CNT_W(CNT_W)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .ce_strap   (strap),
        .start_lim  (start_lim),
        .high_lim   (high_lim),
        .low_lim    (low_lim),
        .sda_pull_o (sda_pull_o),
        .sel_o      (sel_o),
        .rw_o       (rw_o),
        .timeout_o  (timeout_o)
    );

    always @(negedge clk) if (rst_n && timeout_o) tmo_total++;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_bit(input bit v, input int lo, input int hi);
        tick(lo / 2);
        msda = v;
        tick(lo - lo / 2);
        scl = 1'b1;
        tick(hi);
        scl = 1'b0;
    endtask

    // One select byte plus the ninth bit; optionally opened with a Start.
    task automatic xfer(input logic [7:0] b, input bit with_start, input int n_first,
                        input int hi_bit, input int hi_len,
                        input int lo_bit, input int lo_len,
                        output bit ack, output bit pre, output bit post,
                        output bit sel, output bit rw);
        if (with_start) begin
            msda = 1'b0;
            tick(4);
            scl = 1'b0;
            tick(2);
            msda = b[7];
            tick(n_first - 6);
            scl = 1'b1;
            tick(hi_bit == 7 ? hi_len : H);
            scl = 1'b0;
        end else begin
            send_bit(b[7], H, hi_bit == 7 ? hi_len : H);
        end
        for (int i = 6; i >= 0; i--) begin
            if (i == 0) begin
                tick(H / 2);
                msda = b[0];
                tick(H - H / 2);
                scl = 1'b1;
                tick(hi_bit == 0 ? hi_len : H);
                pre = sda_pull_o;
                scl = 1'b0;
            end else begin
                send_bit(b[i], i == lo_bit ? lo_len : H, i == hi_bit ? hi_len : H);
            end
        end
        if (lo_bit == 0) begin
            tick(lo_len - H);
        end
        tick(H / 2);
        msda = 1'b1;
        tick(H - H / 2);
        scl = 1'b1;
        tick(H / 2);
        ack = sda_pull_o;
        tick(H - H / 2);
        scl = 1'b0;
        tick(4);
        post = sda_pull_o;
        sel = sel_o;
        rw = rw_o;
    endtask

    task automatic do_stop();
        msda = 1'b0;
        tick(H / 2);
        scl = 1'b1;
        tick(H);
        msda = 1'b1;
        tick(H);
    endtask

    function automatic bit exp_match(input logic [7:0] b, input logic [2:0] s);
        return (b[7:4] == 4'b1010) && (b[3:1] == s);
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        bit ack, pre, post, sel, rw, m;
        int t0;
        tick(2);
        check("R1 pull in reset", int'(sda_pull_o), 0);
        check("R1 sel in reset", int'(sel_o), 0);
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check("R1 pull after reset", int'(sda_pull_o), 0);
        check("R1 sel after reset", int'(sel_o), 0);
        check("R1 rw after reset", int'(rw_o), 0);
        check("R1 timeout after reset", int'(timeout_o), 0);
        tick(10);

        // R3 / R4 / R5 / R2: every select byte against strap 5.
        strap = 3'd5;
        for (int b = 0; b < 256; b++) begin
            m = exp_match(8'(b), 3'd5);
            xfer(8'(b), 1'b1, 12, -1, H, -1, H, ack, pre, post, sel, rw);
            check("R3 ack on byte sweep", int'(ack), int'(m));
            check("R4 no pull before bit 8 falls", int'(pre), 0);
            check("R4 pull released after bit 9", int'(post), 0);
            check("R5 sel after ack", int'(sel), int'(m));
            check("R5 rw after ack", int'(rw), m ? int'(b[0]) : 0);
            do_stop();
            check("R2 sel cleared by stop", int'(sel_o), 0);
            check("R2 rw cleared by stop", int'(rw_o), 0);
        end

        // R3: every chip-enable value against every strap value.
        for (int s = 0; s < 8; s++) begin
            strap = 3'(s);
            for (int c = 0; c < 8; c++) begin
                xfer({4'b1010, 3'(c), 1'(c)}, 1'b1, 12, -1, H, -1, H, ack, pre, post, sel, rw);
                check("R3 strap compare", int'(ack), int'(c == s));
                do_stop();
            end
        end
        strap = 3'd5;

        // R6: mismatch puts the block in standby; a matching byte without Start is ignored.
        xfer(8'hA0, 1'b1, 12, -1, H, -1, H, ack, pre, post, sel, rw);
        check("R6 mismatch not acked", int'(ack), 0);
        xfer(8'hAA, 1'b0, 12, -1, H, -1, H, ack, pre, post, sel, rw);
        check("R6 standby ignores matching byte", int'(ack), 0);
        check("R6 standby not selected", int'(sel), 0);
        do_stop();

        // R11: Stop in mid-byte, then remaining traffic ignored.
        msda = 1'b0;
        tick(4);
        scl = 1'b0;
        send_bit(1'b1, H, H);
        send_bit(1'b0, H, H);
        send_bit(1'b1, H, H);
        do_stop();
        scl = 1'b0;
        xfer(8'hAA, 1'b0, 12, -1, H, -1, H, ack, pre, post, sel, rw);
        check("R11 bits after mid-byte stop ignored", int'(ack), 0);
        do_stop();

        // R11: repeated Start in mid-byte restarts reception.
        msda = 1'b0;
        tick(4);
        scl = 1'b0;
        send_bit(1'b1, H, H);
        send_bit(1'b1, H, H);
        send_bit(1'b1, H, H);
        tick(H / 2);
        msda = 1'b1;
        tick(H / 2);
        scl = 1'b1;
        tick(4);
        xfer(8'hAB, 1'b1, 12, -1, H, -1, H, ack, pre, post, sel, rw);
        check("R11 repeated start byte acked", int'(ack), 1);
        check("R11 repeated start rw", int'(rw), 1);
        do_stop();

        // R7 / R10: Start-to-first-rise window around its limit.
        for (int n = LS - 3; n <= LS + 3; n++) begin
            t0 = tmo_total;
            xfer(8'hAB, 1'b1, n, -1, H, -1, H, ack, pre, post, sel, rw);
            check("R7 start window timeout count", tmo_total - t0, int'(n > LS));
            check("R10 ack after start window", int'(ack), int'(n <= LS));
            do_stop();
        end

        // R8 / R10: stretched high phase on every bit.
        for (int bi = 0; bi < 8; bi++) begin
            for (int n = LH - 1; n <= LH + 1; n++) begin
                t0 = tmo_total;
                xfer(8'hAA, 1'b1, 12, bi, n, -1, H, ack, pre, post, sel, rw);
                check("R8 high phase timeout count", tmo_total - t0, int'(n > LH));
                check("R10 ack after high stretch", int'(ack), int'(n <= LH));
                do_stop();
            end
        end

        // R9 / R10: stretched low phase before every later bit.
        for (int bi = 0; bi < 7; bi++) begin
            for (int n = LL - 1; n <= LL + 1; n++) begin
                t0 = tmo_total;
                xfer(8'hAA, 1'b1, 12, -1, H, bi, n, ack, pre, post, sel, rw);
                check("R9 low phase timeout count", tmo_total - t0, int'(n > LL));
                check("R10 ack after low stretch", int'(ack), int'(n <= LL));
                do_stop();
            end
        end

        // R9 / R10: low timeout while selected drops the selection once.
        t0 = tmo_total;
        xfer(8'hAB, 1'b1, 12, -1, H, -1, H, ack, pre, post, sel, rw);
        check("R5 selected before idle clock", int'(sel), 1);
        tick(LL + 4);
        check("R9 selected low timeout count", tmo_total - t0, 1);
        check("R10 sel cleared by timeout", int'(sel_o), 0);
        check("R10 rw cleared by timeout", int'(rw_o), 0);
        do_stop();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule